// File: doc/BRIEF.md
# Power-Island Request Arbiter

This block turns per-device power-state requests into one packed target word for a power controller. Each of up to 25 client devices is tied by a fixed routing function to one of 13 power islands, or to none. A request carries a PCI-style device state. The block keeps the latest request of every client. For the island that the request touches, it finds the highest-power state wanted by any client on that island. It translates that state into a 2-bit island code and splices the code into the controller's current status word. The result goes out on an apply channel only when it differs from the status word.

Requests are taken one at a time. While a word is being evaluated or is waiting on the controller's acknowledge, the ready output is low. Two more outputs serve the idle governor, and both are combinational from the inputs and the graphics flag. The first is an eligibility flag for deep idle, true when the status word matches a deep-idle target pattern. The second is a veto mask over idle states.

Client routing used by the block and the bench:

| Client | Route |
|---|---|
| 1 to 8 | island equal to the client number |
| 9 to 11 | island 9 (shared) |
| 12 to 19 | island 10 (shared) |
| 20 | island 12 |
| 21 | graphics flag only |
| 0 and 22 to 31 | none |

Island 11 has no client and is never rewritten by a request.

Top module: `psa_arbiter`

## Requirements
- R1: Island n's state sits in bits [2n+1:2n] of the word, coded 0 = on, 1 = clock-gated, 2 = retention, 3 = off. Request codes are 0 = D0, 1 = D1, 2 = D2, 3 = D3hot and 4 = D3cold. D1 maps to 1, D2 maps to 2, and D3hot, D3cold and the unused codes 5 to 7 all map to 3.
- R2: A D0 request maps to 1 when bit 2n of the auto-gating mask is set for island n, and to 0 otherwise. The default mask sets that bit for every island except 4 and 9.
- R3: On a shared island, the code is derived from the lowest request value among the latest requests of all member clients.
- R4: A request equal to the same client's latest stored request produces no apply.
- R5: The candidate word is the status word with only the affected island's field replaced. apply_valid rises only when the candidate differs from the status word.
- R6: Requests from unrouted clients produce no apply. A request from the graphics client produces no apply and sets gfx_off to 1 for any nonzero request and to 0 for D0.
- R7: deep_ok is 1 exactly when (status_word & deep mask) equals the deep mask. The default deep mask is code 3 on islands 1 to 10 and 12.
- R8: With ctrl_busy high, veto_mask is 0x30 (bits 4 and 5). With ctrl_busy low, veto_mask is 0x20 when deep_ok is 0, gfx_off is 0 or deep_en is 0, and 0x00 otherwise.
- R9: apply_word bits 31 to 26, beyond the 13 usable islands, are always 0.
- R10: req_ready is low from the cycle after an accepted request that changes a client's state until apply_ack is taken. apply_valid and apply_word hold steady until apply_ack is high.
- R11: After reset, req_ready is 1, apply_valid is 0, gfx_off is 0 and every latest request is D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_client | input | 5 | Client index |
| req_pstate | input | 3 | Requested device state code |
| status_word | input | 32 | Current island status from the controller |
| ctrl_busy | input | 1 | Controller busy |
| deep_en | input | 1 | Deep idle allowed by software policy |
| apply_valid | output | 1 | New target word offered |
| apply_word | output | 32 | New target word |
| apply_ack | input | 1 | Controller took the target word |
| gfx_off | output | 1 | Graphics client is in a low-power state |
| deep_ok | output | 1 | Status word meets the deep-idle pattern |
| veto_mask | output | 8 | Idle states the governor must skip |

## Verification
Several behaviours are checked by assertions on every cycle. These are the hold of the apply channel until acknowledge, the low ready while a word is pending, the zero upper bits, the veto encoding against busy and eligibility, and the rule that a new word never equals the status word. An accepted request from an unrouted client must also never start an evaluation. The bench's scenarios are needed for the rest. They show that shared islands take the minimum over members, that repeated or equivalent requests stay silent, that auto-gating promotes D0, and that deep_ok appears only once every island in the pattern is off.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int PSA_WORD_W  = 32;
  localparam int PSA_N_ISL   = 13;
  localparam int PSA_N_CLI   = 25;
  localparam int PSA_CLI_W   = 5;
  localparam int PSA_PST_W   = 3;
  localparam int PSA_ISL_W   = 4;

  typedef enum logic [1:0] {
    ISL_ON = 2'd0, ISL_GATED = 2'd1, ISL_RET = 2'd2, ISL_OFF = 2'd3
  } isl_state_e;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0, CK_ISLAND = 2'd1, CK_DISPLAY = 2'd2
  } client_kind_e;

  typedef struct packed {
    client_kind_e           kind;
    logic [PSA_ISL_W-1:0]   island;
  } client_route_t;

  // Fixed client routing (R6 relies on clients 0, 21, 22..31).
  function automatic client_route_t route_of(input int c);
    client_route_t r;
    r.kind   = CK_NONE;
    r.island = '0;
    if (c >= 1 && c <= 8) begin
      r.kind = CK_ISLAND; r.island = PSA_ISL_W'(c);
    end else if (c >= 9 && c <= 11) begin
      r.kind = CK_ISLAND; r.island = PSA_ISL_W'(9);
    end else if (c >= 12 && c <= 19) begin
      r.kind = CK_ISLAND; r.island = PSA_ISL_W'(10);
    end else if (c == 20) begin
      r.kind = CK_ISLAND; r.island = PSA_ISL_W'(12);
    end else if (c == 21) begin
      r.kind = CK_DISPLAY;
    end
    return r;
  endfunction

  // Device state to island code; D0 promoted when auto-gating is on.
  function automatic isl_state_e xlate(input logic [PSA_PST_W-1:0] pst,
                                       input logic acg_bit);
    case (pst)
      3'd0:    return acg_bit ? ISL_GATED : ISL_ON;
      3'd1:    return ISL_GATED;
      3'd2:    return ISL_RET;
      default: return ISL_OFF;
    endcase
  endfunction

  // Replace one 2-bit island field of a word.
  function automatic logic [PSA_WORD_W-1:0] splice(
      input logic [PSA_WORD_W-1:0] word,
      input logic [PSA_ISL_W-1:0]  island,
      input logic [1:0]            code);
    logic [PSA_WORD_W-1:0] fmask, fval;
    fmask = PSA_WORD_W'(2'b11) << (2 * island);
    fval  = PSA_WORD_W'(code)  << (2 * island);
    return (word & ~fmask) | fval;
  endfunction

  function automatic logic [PSA_WORD_W-1:0] acg_mask_default();
    logic [PSA_WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < PSA_N_ISL; i++)
      if (i != 4 && i != 9) m[2*i] = 1'b1;
    return m;
  endfunction

  function automatic logic [PSA_WORD_W-1:0] deep_mask_default();
    logic [PSA_WORD_W-1:0] m;
    m = '0;
    for (int i = 1; i < PSA_N_ISL; i++)
      if (i != 11) m[2*i +: 2] = 2'b11;
    return m;
  endfunction
endpackage

// File: rtl/psa_req_store.sv
module psa_req_store #(
  parameter int N_CLI = psa_pkg::PSA_N_CLI,
  parameter int CLI_W = psa_pkg::PSA_CLI_W,
  parameter int PST_W = psa_pkg::PSA_PST_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CLI_W-1:0]       wr_client,
  input  logic [PST_W-1:0]       wr_pst,
  output logic [N_CLI*PST_W-1:0] latest_flat
);
  for (genvar c = 0; c < N_CLI; c++) begin : g_cli
    logic [PST_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              lat_q <= '0;
      else if (wr_en && wr_client == CLI_W'(c)) lat_q <= wr_pst;
    end
    assign latest_flat[c*PST_W +: PST_W] = lat_q;
  end
endmodule

// File: rtl/psa_island_merge.sv
module psa_island_merge #(
  parameter int N_CLI = psa_pkg::PSA_N_CLI,
  parameter int PST_W = psa_pkg::PSA_PST_W,
  parameter int ISL_W = psa_pkg::PSA_ISL_W
) (
  input  logic [N_CLI*PST_W-1:0] latest_flat,
  input  logic [ISL_W-1:0]       island,
  output logic [PST_W-1:0]       min_pst
);
  import psa_pkg::*;
  always_comb begin
    min_pst = '1;
    for (int c = 0; c < N_CLI; c++) begin
      if (route_of(c).kind == CK_ISLAND && route_of(c).island == island &&
          latest_flat[c*PST_W +: PST_W] < min_pst)
        min_pst = latest_flat[c*PST_W +: PST_W];
    end
  end
endmodule

// File: rtl/psa_target_build.sv
module psa_target_build #(
  parameter int WORD_W = psa_pkg::PSA_WORD_W,
  parameter int N_ISL  = psa_pkg::PSA_N_ISL,
  parameter int PST_W  = psa_pkg::PSA_PST_W,
  parameter int ISL_W  = psa_pkg::PSA_ISL_W,
  parameter logic [WORD_W-1:0] ACG_MASK = psa_pkg::acg_mask_default()
) (
  input  logic [WORD_W-1:0] status_word,
  input  logic [ISL_W-1:0]  island,
  input  logic [PST_W-1:0]  min_pst,
  output logic [WORD_W-1:0] new_word,
  output logic              differs
);
  import psa_pkg::*;
  localparam int USED_W = 2 * N_ISL;
  localparam logic [WORD_W-1:0] USABLE = WORD_W'((64'd1 << USED_W) - 64'd1);
  logic [1:0] code;
  always_comb begin
    code     = xlate(min_pst, ACG_MASK[2*island]);
    new_word = splice(status_word, island, code) & USABLE;
    differs  = (new_word != status_word);
  end
endmodule

// File: rtl/psa_eligibility.sv
module psa_eligibility #(
  parameter int WORD_W = psa_pkg::PSA_WORD_W,
  parameter int VETO_W = 8,
  parameter int SHALLOW_BIT = 4,
  parameter int DEEP_BIT = 5,
  parameter logic [WORD_W-1:0] DEEP_MASK = psa_pkg::deep_mask_default()
) (
  input  logic [WORD_W-1:0] status_word,
  input  logic              ctrl_busy,
  input  logic              gfx_off,
  input  logic              deep_en,
  output logic              deep_ok,
  output logic [VETO_W-1:0] veto_mask
);
  always_comb begin
    deep_ok   = ((status_word & DEEP_MASK) == DEEP_MASK);
    veto_mask = '0;
    if (ctrl_busy) begin
      veto_mask[SHALLOW_BIT] = 1'b1;
      veto_mask[DEEP_BIT]    = 1'b1;
    end else if (!deep_ok || !gfx_off || !deep_en) begin
      veto_mask[DEEP_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/psa_arbiter.sv
module psa_arbiter #(
  parameter int WORD_W = psa_pkg::PSA_WORD_W,
  parameter int N_ISL  = psa_pkg::PSA_N_ISL,
  parameter int N_CLI  = psa_pkg::PSA_N_CLI,
  parameter int CLI_W  = psa_pkg::PSA_CLI_W,
  parameter int PST_W  = psa_pkg::PSA_PST_W,
  parameter int ISL_W  = psa_pkg::PSA_ISL_W,
  parameter int VETO_W = 8,
  parameter logic [WORD_W-1:0] ACG_MASK  = psa_pkg::acg_mask_default(),
  parameter logic [WORD_W-1:0] DEEP_MASK = psa_pkg::deep_mask_default()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CLI_W-1:0]  req_client,
  input  logic [PST_W-1:0]  req_pstate,
  input  logic [WORD_W-1:0] status_word,
  input  logic              ctrl_busy,
  input  logic              deep_en,
  output logic              apply_valid,
  output logic [WORD_W-1:0] apply_word,
  input  logic              apply_ack,
  output logic              gfx_off,
  output logic              deep_ok,
  output logic [VETO_W-1:0] veto_mask
);
  import psa_pkg::*;

  logic [N_CLI*PST_W-1:0] latest_flat;
  client_route_t          route;
  logic [PST_W-1:0]       prev_pst, min_pst;
  logic [CLI_W-1:0]       safe_idx;
  logic                   accept_evt, store_evt, gfx_evt, eval_evt;
  logic [ISL_W-1:0]       pend_island;
  logic [WORD_W-1:0]      new_word;
  logic                   differs;

  // Named events used by the checker.
  assign accept_evt = req_valid && req_ready;
  assign route      = route_of(int'(req_client));
  assign safe_idx   = (int'(req_client) < N_CLI) ? req_client : '0;
  assign prev_pst   = latest_flat[safe_idx*PST_W +: PST_W];
  assign store_evt  = accept_evt && route.kind == CK_ISLAND && req_pstate != prev_pst;
  assign gfx_evt    = accept_evt && route.kind == CK_DISPLAY;
  assign req_ready  = !eval_evt && !apply_valid;

  psa_req_store #(.N_CLI(N_CLI), .CLI_W(CLI_W), .PST_W(PST_W)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(store_evt), .wr_client(req_client),
    .wr_pst(req_pstate), .latest_flat(latest_flat));

  psa_island_merge #(.N_CLI(N_CLI), .PST_W(PST_W), .ISL_W(ISL_W)) merge_i (
    .latest_flat(latest_flat), .island(pend_island), .min_pst(min_pst));

  psa_target_build #(.WORD_W(WORD_W), .N_ISL(N_ISL), .PST_W(PST_W),
                     .ISL_W(ISL_W), .ACG_MASK(ACG_MASK)) build_i (
    .status_word(status_word), .island(pend_island), .min_pst(min_pst),
    .new_word(new_word), .differs(differs));

  psa_eligibility #(.WORD_W(WORD_W), .VETO_W(VETO_W),
                    .DEEP_MASK(DEEP_MASK)) elig_i (
    .status_word(status_word), .ctrl_busy(ctrl_busy), .gfx_off(gfx_off),
    .deep_en(deep_en), .deep_ok(deep_ok), .veto_mask(veto_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_evt    <= 1'b0;
      pend_island <= '0;
      gfx_off     <= 1'b0;
      apply_valid <= 1'b0;
      apply_word  <= '0;
    end else begin
      eval_evt <= store_evt;
      if (store_evt) pend_island <= route.island;
      if (gfx_evt)   gfx_off     <= (req_pstate != '0);
      if (eval_evt && differs) begin
        apply_valid <= 1'b1;
        apply_word  <= new_word;
      end else if (apply_valid && apply_ack) begin
        apply_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/psa_arbiter_chk.sv
module psa_arbiter_chk #(
  parameter int WORD_W = 32,
  parameter int N_ISL  = 13,
  parameter int CLI_W  = 5,
  parameter int VETO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [CLI_W-1:0]  req_client,
  input logic              accept_evt,
  input logic              eval_evt,
  input logic              apply_valid,
  input logic [WORD_W-1:0] apply_word,
  input logic              apply_ack,
  input logic [WORD_W-1:0] status_word,
  input logic              ctrl_busy,
  input logic              deep_ok,
  input logic [VETO_W-1:0] veto_mask
);
  import psa_pkg::*;
  localparam int USED_W = 2 * N_ISL;

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    apply_valid && !apply_ack |=> apply_valid && $stable(apply_word));
  assert_stall_while_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_valid || eval_evt) |-> !req_ready);
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    apply_valid |-> apply_word[WORD_W-1:USED_W] == '0);
  assert_new_differs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(apply_valid) |-> apply_word != status_word);
  assert_busy_veto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_busy |-> veto_mask == VETO_W'(8'h30));
  assert_ineligible_veto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_busy && !deep_ok |-> veto_mask == VETO_W'(8'h20));
  assert_unrouted_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && route_of(int'(req_client)).kind != CK_ISLAND |=> !eval_evt);
endmodule

bind psa_arbiter psa_arbiter_chk #(.WORD_W(WORD_W), .N_ISL(N_ISL),
                                   .CLI_W(CLI_W), .VETO_W(VETO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_client(req_client),
  .accept_evt(accept_evt), .eval_evt(eval_evt), .apply_valid(apply_valid),
  .apply_word(apply_word), .apply_ack(apply_ack), .status_word(status_word),
  .ctrl_busy(ctrl_busy), .deep_ok(deep_ok), .veto_mask(veto_mask));

// File: tb/psa_arbiter_tb_top.sv
`timescale 1ns/1ps
module psa_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_client = '0;
  logic [2:0]  req_pstate = '0;
  logic [31:0] status_word = '0;
  logic        ctrl_busy = 1'b0;
  logic        deep_en = 1'b1;
  logic        apply_valid;
  logic [31:0] apply_word;
  logic        apply_ack = 1'b0;
  logic        gfx_off, deep_ok;
  logic [7:0]  veto_mask;

  always #2.5 clk = ~clk;

  psa_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_client(req_client), .req_pstate(req_pstate), .status_word(status_word),
    .ctrl_busy(ctrl_busy), .deep_en(deep_en), .apply_valid(apply_valid),
    .apply_word(apply_word), .apply_ack(apply_ack), .gfx_off(gfx_off),
    .deep_ok(deep_ok), .veto_mask(veto_mask));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string cur_tag = "R1";
  logic [31:0] exp_q[$];
  logic [2:0]  lat_m[32];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Bench view of routing: returns island, or -1 none, -2 graphics.
  function automatic int island_of(input int c);
    if (c == 21) return -2;
    if (c == 20) return 12;
    if (c >= 12 && c <= 19) return 10;
    if (c >= 9 && c <= 11) return 9;
    if (c >= 1 && c <= 8) return c;
    return -1;
  endfunction

  function automatic logic [1:0] code_of(input logic [2:0] p, input int isl);
    if (p == 0) return (isl == 4 || isl == 9) ? 2'd0 : 2'd1;
    if (p == 1) return 2'd1;
    if (p == 2) return 2'd2;
    return 2'd3;
  endfunction

  task automatic send(input int c, input logic [2:0] p, input string tag);
    int isl;
    logic [2:0] m;
    logic [31:0] e;
    cur_tag = tag;
    isl = island_of(c);
    if (isl >= 0 && p != lat_m[c]) begin
      lat_m[c] = p;
      m = 3'd7;
      for (int k = 0; k < 32; k++)
        if (island_of(k) == isl && lat_m[k] < m) m = lat_m[k];
      e = status_word;
      e[2*isl +: 2] = code_of(m, isl);
      if (e != status_word) exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b1; req_client = 5'(c); req_pstate = p;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    while (apply_valid || !req_ready) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, {tag, " missing apply"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  // Controller model: acknowledge two cycles after an offer.
  initial begin
    forever begin
      @(negedge clk);
      apply_ack = 1'b0;
      if (apply_valid) begin
        repeat (2) @(negedge clk);
        status_word = apply_word;
        apply_ack = 1'b1;
      end
    end
  end

  // Monitor: compare each new offer with the scoreboard queue.
  initial begin
    bit seen = 0;
    logic [31:0] e;
    forever begin
      @(negedge clk);
      if (!apply_valid) seen = 0;
      else if (!seen) begin
        seen = 1;
        if (exp_q.size() == 0) begin
          check(0, {cur_tag, " unexpected apply (R4/R5/R6)"}, apply_word, status_word);
        end else begin
          e = exp_q.pop_front();
          check(apply_word == e, cur_tag, apply_word, e);
        end
        check(apply_word[31:26] == 6'd0, "R9", 32'(apply_word[31:26]), 32'd0);
        check(!req_ready, "R10 ready low while pending", 32'(req_ready), 32'd0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    foreach (lat_m[i]) lat_m[i] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);
    check(apply_valid == 1'b0, "R11 apply_valid", 32'(apply_valid), 32'd0);
    check(gfx_off == 1'b0, "R11 gfx_off", 32'(gfx_off), 32'd0);
    check(veto_mask == 8'h20, "R8 reset veto", 32'(veto_mask), 32'h20);
    check(deep_ok == 1'b0, "R7 reset deep_ok", 32'(deep_ok), 32'd0);
    // R1 translation and field position
    send(1, 3'd1, "R1");
    send(1, 3'd2, "R1");
    send(1, 3'd3, "R1");
    send(1, 3'd4, "R5");  // D3cold after D3hot: same code, no apply
    send(1, 3'd4, "R4");  // repeat of latest request
    send(3, 3'd6, "R1");  // unused code maps to off
    // R2 auto-gating promotion
    send(2, 3'd2, "R2");
    send(2, 3'd0, "R2");
    send(4, 3'd2, "R2");
    send(4, 3'd0, "R2");
    // R3 shared islands
    send(12, 3'd3, "R3");
    for (int c = 13; c <= 19; c++) send(c, 3'd3, "R3");
    send(9, 3'd2, "R3");
    send(10, 3'd3, "R3");
    send(11, 3'd1, "R3");
    send(12, 3'd0, "R3");
    // R6 unrouted and graphics clients
    send(0, 3'd3, "R6");
    send(23, 3'd3, "R6");
    send(21, 3'd3, "R6");
    check(gfx_off == 1'b1, "R6 gfx_off set", 32'(gfx_off), 32'd1);
    check(veto_mask == 8'h20, "R8 ineligible veto", 32'(veto_mask), 32'h20);
    // Bring every deep-pattern island to off
    for (int c = 2; c <= 20; c++) send(c, 3'd3, "R7");
    check(status_word[31:26] == 6'd0, "R9 status upper", 32'(status_word[31:26]), 32'd0);
    check(deep_ok == 1'b1, "R7 deep_ok", 32'(deep_ok), 32'd1);
    check(veto_mask == 8'h00, "R8 all clear", 32'(veto_mask), 32'h00);
    deep_en = 1'b0;
    @(negedge clk);
    check(veto_mask == 8'h20, "R8 disabled", 32'(veto_mask), 32'h20);
    deep_en = 1'b1;
    ctrl_busy = 1'b1;
    @(negedge clk);
    check(veto_mask == 8'h30, "R8 busy", 32'(veto_mask), 32'h30);
    ctrl_busy = 1'b0;
    send(21, 3'd0, "R6");
    check(gfx_off == 1'b0, "R6 gfx_off clear", 32'(gfx_off), 32'd0);
    check(veto_mask == 8'h20, "R8 graphics on", 32'(veto_mask), 32'h20);
    send(15, 3'd1, "R3");  // one member wakes: island 10 to gated
    check(deep_ok == 1'b0, "R7 deep lost", 32'(deep_ok), 32'd0);
    finish_run();
  end
endmodule